// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one write-back cache's lines coherent with its peers on a shared snooping bus. Each line is direct-mapped by the low address bits. A line holds a state (invalid, shared or modified), a tag and one data word. The local side sends load, store and evict requests. The controller finishes hits at once and turns misses and upgrades into bus messages. It then waits for the matching reply before it installs the line.

The snoop port carries the messages of every other agent. The controller watches them for addresses it holds. When it owns a dirty copy it answers reads with a reply that carries the data, and it downgrades or drops its own copy. Memory also observes owner replies, so a line it gives up is clean from then on. Bus arbitration, memory and the processor are outside the block.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `resp_valid` and `bus_valid` are low, and `req_ready` is high once reset is released.
- R2: A load that hits a shared or modified line, or a store that hits a modified line, is answered by `resp_valid` in the cycle after acceptance with no bus message. `resp_rdata` carries the line's data (for a store, the new data).
- R3: A load miss emits a read (`bus_cmd`=1, data zero) in the cycle after acceptance. It installs the line as shared when a reply (`bus_cmd`=5) with the same address arrives on the snoop port, and answers with the reply data in the following cycle.
- R4: A store miss emits a read-exclusive (`bus_cmd`=2, data zero) and installs the line as modified, holding the store data, on the matching reply.
- R5: A store to a shared line emits an invalidate (`bus_cmd`=3) with zero data. The line becomes modified and the request completes in the cycle after acceptance.
- R6: A shared line drops to invalid when it snoops a read-exclusive or an invalidate to its address.
- R7: A modified line that snoops a read emits a reply with its data in the next cycle and becomes shared.
- R8: A modified line that snoops a read-exclusive emits a reply with its data in the next cycle and becomes invalid.
- R9: Evicting a modified line emits a write-back (`bus_cmd`=4) with its address and data. Evicting a shared line, or an address not held, sends nothing. All evicts complete in the cycle after acceptance.
- R10: A miss whose line slot holds a modified line with another tag first writes that line back. The read or read-exclusive follows in the next cycle. A shared victim is dropped without a message.
- R11: `req_ready` is low while a miss is outstanding and in any cycle where the snoop port is valid.

Request operations: `req_op` 0 = load, 1 = store, 2 = evict. The line index is the low log2(LINES) address bits and the tag is the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | 0 load, 1 store, 2 evict |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| resp_valid | output | 1 | Request completed (one-cycle pulse) |
| resp_rdata | output | DATA_W | Load data or stored data |
| snp_valid | input | 1 | Message from another agent present |
| snp_cmd | input | 3 | Snooped message code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_data | input | DATA_W | Snooped data (replies) |
| bus_valid | output | 1 | Outgoing message present |
| bus_cmd | output | 3 | Outgoing message code: 1 read, 2 read-exclusive, 3 invalidate, 4 write-back, 5 reply |
| bus_addr | output | ADDR_W | Outgoing address |
| bus_data | output | DATA_W | Outgoing data |

## Verification
Hits, upgrades and evicts respond, and put any message on the bus, exactly one cycle after the accepting edge. A victim write-back pushes the miss message one cycle later. A peer's owner reply appears one cycle after the snooped request, and the requester's response comes one cycle after that reply. The bench turns each request into a list of events tagged with their absolute cycle numbers. On every falling edge it checks, for both caches, that each output is present exactly when an event is due, with the predicted command, address and data.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LN_INV = 2'd0, LN_SHR = 2'd1, LN_MOD = 2'd2} line_st_e;
  typedef enum logic [2:0] {
    BC_NONE = 3'd0, BC_RD = 3'd1, BC_RDX = 3'd2, BC_INV = 3'd3, BC_WB = 3'd4, BC_REPLY = 3'd5
  } bus_cmd_e;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_EVICT = 2'd2} req_op_e;
  typedef enum logic [1:0] {CT_IDLE = 2'd0, CT_ISSUE = 2'd1, CT_WAIT = 2'd2} ctl_st_e;
endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_e          ra_st,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_e          rb_st,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              wr_en,
  input  logic              wr_fill,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_st,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sn_en,
  input  logic [IDX_W-1:0]  sn_idx,
  input  line_st_e          sn_st
);
  line_st_e          st_all   [LINES];
  logic [TAG_W-1:0]  tag_all  [LINES];
  logic [DATA_W-1:0] data_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              own_wr, own_sn;

    assign own_wr = wr_en && (wr_idx == IDX_W'(g));
    assign own_sn = sn_en && (sn_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= LN_INV;
      else if (own_wr) st_q <= wr_st;
      else if (own_sn) st_q <= sn_st;
    end

    always_ff @(posedge clk) begin
      if (own_wr && wr_fill) begin
        tag_q  <= wr_tag;
        data_q <= wr_data;
      end
    end

    assign st_all[g]   = st_q;
    assign tag_all[g]  = tag_q;
    assign data_all[g] = data_q;
  end

  assign ra_st   = st_all[ra_idx];
  assign ra_tag  = tag_all[ra_idx];
  assign ra_data = data_all[ra_idx];
  assign rb_st   = st_all[rb_idx];
  assign rb_tag  = tag_all[rb_idx];
  assign rb_data = data_all[rb_idx];
endmodule

// File: rtl/msi_snoop_decide.sv
module msi_snoop_decide
  import msi_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              upd,
  output line_st_e          new_st,
  output logic              reply_v,
  output logic [DATA_W-1:0] reply_data
);
  logic held;

  assign held       = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);
  assign reply_data = line_data;

  always_comb begin
    upd     = 1'b0;
    new_st  = line_st;
    reply_v = 1'b0;
    if (held) begin
      unique case (bus_cmd_e'(snp_cmd))
        BC_RD: if (line_st == LN_MOD) begin
          upd = 1'b1; new_st = LN_SHR; reply_v = 1'b1;
        end
        BC_RDX: begin
          upd = 1'b1; new_st = LN_INV; reply_v = (line_st == LN_MOD);
        end
        BC_INV: if (line_st == LN_SHR) begin
          upd = 1'b1; new_st = LN_INV;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  output logic              bus_valid,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic rst_n_s;
  msi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  ctl_st_e           ctl_q, ctl_d;
  req_op_e           p_op_q;
  logic [ADDR_W-1:0] p_addr_q;
  logic [DATA_W-1:0] p_wdata_q;
  logic              lat_en;
  logic              bo_v_d, rs_v_d;
  bus_cmd_e          bo_cmd_d;
  logic [ADDR_W-1:0] bo_addr_d;
  logic [DATA_W-1:0] bo_data_d, rs_data_d;

  line_st_e          a_st, b_st, wr_st, sn_st;
  logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
  logic [DATA_W-1:0] a_data, b_data, wr_data, sn_rdata;
  logic              wr_en, wr_fill, sn_upd, sn_reply;
  logic [IDX_W-1:0]  wr_idx;
  logic              accept, a_hit;
  req_op_e           op;
  bus_cmd_e          miss_cmd, p_miss_cmd;

  msi_line_array #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n_s),
    .ra_idx(req_addr[IDX_W-1:0]), .ra_st(a_st), .ra_tag(a_tag), .ra_data(a_data),
    .rb_idx(snp_addr[IDX_W-1:0]), .rb_st(b_st), .rb_tag(b_tag), .rb_data(b_data),
    .wr_en(wr_en), .wr_fill(wr_fill), .wr_idx(wr_idx), .wr_st(wr_st),
    .wr_tag(wr_tag), .wr_data(wr_data),
    .sn_en(sn_upd), .sn_idx(snp_addr[IDX_W-1:0]), .sn_st(sn_st)
  );

  msi_snoop_decide #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .line_st(b_st), .line_tag(b_tag), .line_data(b_data),
    .upd(sn_upd), .new_st(sn_st), .reply_v(sn_reply), .reply_data(sn_rdata)
  );

  assign req_ready  = (ctl_q == CT_IDLE) && !snp_valid;
  assign accept     = req_valid && req_ready;
  assign op         = req_op_e'(req_op);
  assign a_hit      = (a_st != LN_INV) && (a_tag == req_addr[ADDR_W-1:IDX_W]);
  assign miss_cmd   = (op == OP_STORE) ? BC_RDX : BC_RD;
  assign p_miss_cmd = (p_op_q == OP_STORE) ? BC_RDX : BC_RD;

  always_comb begin
    ctl_d     = ctl_q;
    lat_en    = 1'b0;
    bo_v_d    = 1'b0;
    bo_cmd_d  = BC_NONE;
    bo_addr_d = '0;
    bo_data_d = '0;
    rs_v_d    = 1'b0;
    rs_data_d = resp_rdata;
    wr_en     = 1'b0;
    wr_fill   = 1'b0;
    wr_idx    = req_addr[IDX_W-1:0];
    wr_st     = LN_INV;
    wr_tag    = req_addr[ADDR_W-1:IDX_W];
    wr_data   = req_wdata;
    if (sn_reply) begin
      bo_v_d = 1'b1; bo_cmd_d = BC_REPLY; bo_addr_d = snp_addr; bo_data_d = sn_rdata;
    end
    unique case (ctl_q)
      CT_IDLE: if (accept) begin
        lat_en = 1'b1;
        if (op == OP_EVICT) begin
          rs_v_d = 1'b1; rs_data_d = '0;
          if (a_hit) wr_en = 1'b1;
          if (a_hit && a_st == LN_MOD) begin
            bo_v_d = 1'b1; bo_cmd_d = BC_WB; bo_addr_d = req_addr; bo_data_d = a_data;
          end
        end else if (a_hit && op == OP_LOAD) begin
          rs_v_d = 1'b1; rs_data_d = a_data;
        end else if (a_hit) begin
          wr_en = 1'b1; wr_fill = 1'b1; wr_st = LN_MOD;
          rs_v_d = 1'b1; rs_data_d = req_wdata;
          if (a_st == LN_SHR) begin
            bo_v_d = 1'b1; bo_cmd_d = BC_INV; bo_addr_d = req_addr;
          end
        end else begin
          wr_en = 1'b1;
          if (a_st == LN_MOD) begin
            bo_v_d = 1'b1; bo_cmd_d = BC_WB; bo_addr_d = {a_tag, req_addr[IDX_W-1:0]};
            bo_data_d = a_data; ctl_d = CT_ISSUE;
          end else begin
            bo_v_d = 1'b1; bo_cmd_d = miss_cmd; bo_addr_d = req_addr; ctl_d = CT_WAIT;
          end
        end
      end
      CT_ISSUE: if (!sn_reply) begin
        bo_v_d = 1'b1; bo_cmd_d = p_miss_cmd; bo_addr_d = p_addr_q; ctl_d = CT_WAIT;
      end
      CT_WAIT: if (snp_valid && bus_cmd_e'(snp_cmd) == BC_REPLY && snp_addr == p_addr_q) begin
        wr_en   = 1'b1;
        wr_fill = 1'b1;
        wr_idx  = p_addr_q[IDX_W-1:0];
        wr_tag  = p_addr_q[ADDR_W-1:IDX_W];
        wr_st   = (p_op_q == OP_STORE) ? LN_MOD : LN_SHR;
        wr_data = (p_op_q == OP_STORE) ? p_wdata_q : snp_data;
        rs_v_d  = 1'b1;
        rs_data_d = wr_data;
        ctl_d   = CT_IDLE;
      end
      default: ctl_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q      <= CT_IDLE;
      bus_valid  <= 1'b0;
      bus_cmd    <= '0;
      bus_addr   <= '0;
      bus_data   <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      p_op_q     <= OP_LOAD;
      p_addr_q   <= '0;
      p_wdata_q  <= '0;
    end else begin
      ctl_q      <= ctl_d;
      bus_valid  <= bo_v_d;
      bus_cmd    <= bo_cmd_d;
      bus_addr   <= bo_addr_d;
      bus_data   <= bo_data_d;
      resp_valid <= rs_v_d;
      resp_rdata <= rs_data_d;
      if (lat_en) begin
        p_op_q    <= op;
        p_addr_q  <= req_addr;
        p_wdata_q <= req_wdata;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              snp_valid,
  input logic [2:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              bus_valid,
  input logic [2:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data
);
  // R11
  a_r11_busy_on_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready);
  // R5 (also R3, R4)
  a_r5_ctrl_msg_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_cmd == 3'd1 || bus_cmd == 3'd2 || bus_cmd == 3'd3)) |-> bus_data == '0);
  // R2
  a_r2_accept_acts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (resp_valid || bus_valid));
  // R7, R8
  a_r7_reply_follows_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == 3'd5) |->
      ($past(snp_valid) && ($past(snp_cmd) == 3'd1 || $past(snp_cmd) == 3'd2)
       && bus_addr == $past(snp_addr)));
  // R3
  a_r3_resp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($past(req_valid && req_ready) || ($past(snp_valid) && $past(snp_cmd) == 3'd5)));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_data(bus_data)
);

// File: tb/msi_snoop_ctrl_bench.sv
module msi_snoop_ctrl_bench;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NL = 4;
  localparam int NA = 1 << AW;

  logic clk, rst_n;
  logic          rq_v  [2];
  logic [1:0]    rq_op [2];
  logic [AW-1:0] rq_a  [2];
  logic [DW-1:0] rq_wd [2];
  logic          rdy   [2];
  logic          rs_v  [2];
  logic [DW-1:0] rs_d  [2];
  logic          bi_v  [2];
  logic [2:0]    bi_c  [2];
  logic [AW-1:0] bi_a  [2];
  logic [DW-1:0] bi_d  [2];
  logic          bo_v  [2];
  logic [2:0]    bo_c  [2];
  logic [AW-1:0] bo_a  [2];
  logic [DW-1:0] bo_d  [2];

  int checks, fails, cyc;
  bit mon_on;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(rq_v[0]), .req_op(rq_op[0]), .req_addr(rq_a[0]),
    .req_wdata(rq_wd[0]), .req_ready(rdy[0]), .resp_valid(rs_v[0]), .resp_rdata(rs_d[0]),
    .snp_valid(bi_v[0]), .snp_cmd(bi_c[0]), .snp_addr(bi_a[0]), .snp_data(bi_d[0]),
    .bus_valid(bo_v[0]), .bus_cmd(bo_c[0]), .bus_addr(bo_a[0]), .bus_data(bo_d[0]));

  msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_msi_snoop_ctrl_peer (
    .clk(clk), .rst_n(rst_n), .req_valid(rq_v[1]), .req_op(rq_op[1]), .req_addr(rq_a[1]),
    .req_wdata(rq_wd[1]), .req_ready(rdy[1]), .resp_valid(rs_v[1]), .resp_rdata(rs_d[1]),
    .snp_valid(bi_v[1]), .snp_cmd(bi_c[1]), .snp_addr(bi_a[1]), .snp_data(bi_d[1]),
    .bus_valid(bo_v[1]), .bus_cmd(bo_c[1]), .bus_addr(bo_a[1]), .bus_data(bo_d[1]));

  // Memory environment: answers reads one cycle later, absorbs write-backs and owner replies.
  logic [DW-1:0] mem [NA];
  logic          mem_v;
  int            mem_t;
  logic [AW-1:0] mem_a;
  logic [DW-1:0] mem_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) mem[i] <= DW'(i * 7 + 3);
      mem_v <= 1'b0;
    end else begin
      mem_v <= 1'b0;
      for (int c = 0; c < 2; c++) begin
        if (bo_v[c] && (bo_c[c] == 3'd1 || bo_c[c] == 3'd2)) begin
          mem_v <= 1'b1; mem_t <= c; mem_a <= bo_a[c]; mem_d <= mem[bo_a[c]];
        end
        if (bo_v[c] && (bo_c[c] == 3'd4 || bo_c[c] == 3'd5)) mem[bo_a[c]] <= bo_d[c];
      end
    end
  end

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      if (bo_v[1-c]) begin
        bi_v[c] = 1'b1; bi_c[c] = bo_c[1-c]; bi_a[c] = bo_a[1-c]; bi_d[c] = bo_d[1-c];
      end else if (mem_v && mem_t == c) begin
        bi_v[c] = 1'b1; bi_c[c] = 3'd5; bi_a[c] = mem_a; bi_d[c] = mem_d;
      end else begin
        bi_v[c] = 1'b0; bi_c[c] = '0; bi_a[c] = '0; bi_d[c] = '0;
      end
    end
  end

  // Reference model
  int mst [2][NL];
  int mtag[2][NL];
  int mdat[2][NL];
  int mmem[NA];

  typedef struct {int who; int kd; int cyc; int cmd; int addr; int data; bit chkd; int rq;} ev_t;
  ev_t evq[$];

  task automatic add(input int who, input int kd, input int cy, input int cmd,
                     input int addr, input int data, input bit chkd, input int rq);
    ev_t e;
    e.who = who; e.kd = kd; e.cyc = cy; e.cmd = cmd; e.addr = addr;
    e.data = data & 255; e.chkd = chkd; e.rq = rq;
    evq.push_back(e);
  endtask

  task automatic ck(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", rq, cyc, act, exp);
    end
  endtask

  // Per-clock comparison of both caches against the due events.
  always @(negedge clk) begin
    if (mon_on) begin
      for (int c = 0; c < 2; c++) begin
        for (int kd = 0; kd < 2; kd++) begin
          int fi;
          bit ov;
          fi = -1;
          for (int i = 0; i < evq.size(); i++)
            if (evq[i].who == c && evq[i].kd == kd && evq[i].cyc == cyc) fi = i;
          ov = (kd == 0) ? bo_v[c] : rs_v[c];
          checks++;
          if (fi < 0) begin
            if (ov) begin
              fails++;
              $display("FAIL R2 cache%0d unexpected %s cyc=%0d actual=1 expected=0",
                       c, kd ? "resp" : "bus", cyc);
            end
          end else begin
            ev_t e;
            bit ok;
            e = evq[fi];
            evq.delete(fi);
            if (kd == 0)
              ok = bo_v[c] && int'(bo_c[c]) == e.cmd && int'(bo_a[c]) == e.addr
                   && int'(bo_d[c]) == e.data;
            else
              ok = rs_v[c] && (!e.chkd || int'(rs_d[c]) == e.data);
            if (!ok) begin
              fails++;
              if (kd == 0)
                $display("FAIL R%0d cache%0d bus cyc=%0d actual=v%0d c%0d a%0h d%0h expected=c%0d a%0h d%0h",
                         e.rq, c, cyc, bo_v[c], bo_c[c], bo_a[c], bo_d[c], e.cmd, e.addr, e.data);
              else
                $display("FAIL R%0d cache%0d resp cyc=%0d actual=v%0d d%0h expected=d%0h",
                         e.rq, c, cyc, rs_v[c], rs_d[c], e.data);
            end
          end
        end
      end
    end
  end

  task automatic do_op(input int c, input int op, input int a, input int wd, input int rq);
    int o, idx, tg, n, k, vd;
    bit hit, miss, ohit;
    @(posedge clk); #1;
    n = cyc + 1; o = 1 - c; idx = a % NL; tg = a / NL; wd = wd & 255;
    hit  = mst[c][idx] != 0 && mtag[c][idx] == tg;
    ohit = mst[o][idx] != 0 && mtag[o][idx] == tg;
    miss = 1'b0;
    ck(rdy[c] == 1'b1, "R11 ready when idle", int'(rdy[c]), 1);
    if (op == 0 && hit) begin
      add(c, 1, n, 0, 0, mdat[c][idx], 1, rq);
    end else if (op == 1 && hit && mst[c][idx] == 2) begin
      mdat[c][idx] = wd; add(c, 1, n, 0, 0, wd, 1, rq);
    end else if (op == 1 && hit) begin
      add(c, 0, n, 3, a, 0, 1, rq);
      if (ohit) mst[o][idx] = 0;
      mst[c][idx] = 2; mdat[c][idx] = wd;
      add(c, 1, n, 0, 0, wd, 1, rq);
    end else if (op == 2) begin
      if (hit && mst[c][idx] == 2) begin
        add(c, 0, n, 4, a, mdat[c][idx], 1, rq); mmem[a] = mdat[c][idx];
      end
      if (hit) mst[c][idx] = 0;
      add(c, 1, n, 0, 0, 0, 0, rq);
    end else begin
      miss = 1'b1; k = n;
      if (mst[c][idx] == 2) begin
        add(c, 0, n, 4, mtag[c][idx] * NL + idx, mdat[c][idx], 1, 10);
        mmem[mtag[c][idx] * NL + idx] = mdat[c][idx];
        k = n + 1;
      end
      mst[c][idx] = 0;
      add(c, 0, k, (op == 1) ? 2 : 1, a, 0, 1, rq);
      vd = mmem[a];
      if (ohit) begin
        if (mst[o][idx] == 2) begin
          add(o, 0, k + 1, 5, a, mdat[o][idx], 1, (op == 1) ? 8 : 7);
          vd = mdat[o][idx]; mmem[a] = vd;
          mst[o][idx] = (op == 1) ? 0 : 1;
        end else if (op == 1) mst[o][idx] = 0;
      end
      mst[c][idx] = (op == 1) ? 2 : 1; mtag[c][idx] = tg;
      mdat[c][idx] = (op == 1) ? wd : vd;
      add(c, 1, k + 2, 0, 0, mdat[c][idx], 1, rq);
    end
    rq_v[c] = 1'b1; rq_op[c] = 2'(op); rq_a[c] = AW'(a); rq_wd[c] = DW'(wd);
    @(posedge clk); #1;
    rq_v[c] = 1'b0;
    ck(rdy[c] == !miss, "R11 ready after accept", int'(rdy[c]), int'(!miss));
    repeat (5) @(posedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0; mon_on = 1'b0;
    for (int c = 0; c < 2; c++) begin
      rq_v[c] = 1'b0; rq_op[c] = '0; rq_a[c] = '0; rq_wd[c] = '0;
      for (int i = 0; i < NL; i++) begin mst[c][i] = 0; mtag[c][i] = 0; mdat[c][i] = 0; end
    end
    for (int i = 0; i < NA; i++) mmem[i] = (i * 7 + 3) & 255;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      ck(rs_v[c] == 1'b0, "R1 resp idle in reset", int'(rs_v[c]), 0);
      ck(bo_v[c] == 1'b0, "R1 bus idle in reset", int'(bo_v[c]), 0);
    end
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    mon_on = 1'b1;
    for (int c = 0; c < 2; c++) ck(rdy[c] == 1'b1, "R1 ready after reset", int'(rdy[c]), 1);
    do_op(0, 0, 5, 0, 3);      // R3 load miss, lines start invalid (R1)
    do_op(0, 0, 5, 0, 2);      // R2 load hit shared
    do_op(1, 0, 5, 0, 3);      // R3 peer load miss, both shared
    do_op(0, 1, 5, 'hA1, 5);   // R5 upgrade, peer drops (R6)
    do_op(1, 0, 5, 0, 6);      // R6 peer misses again; R7 owner replies
    do_op(0, 1, 5, 'hB2, 5);   // R5 second upgrade after R7 downgrade to shared
    do_op(1, 1, 5, 'hC3, 4);   // R4 store miss; R8 owner replies and drops
    do_op(0, 0, 5, 0, 7);      // R7 peer owner supplies data
    do_op(1, 2, 5, 0, 9);      // R9 silent evict of shared line
    do_op(0, 1, 9, 'h44, 4);   // R4 store miss from memory
    do_op(0, 1, 9, 'h45, 2);   // R2 store hit modified
    do_op(0, 0, 13, 0, 10);    // R10 modified victim written back first
    do_op(0, 0, 17, 0, 10);    // R10 shared victim dropped silently
    do_op(0, 1, 2, 'h5A, 4);   // R4
    do_op(0, 2, 2, 0, 9);      // R9 write-back on evict of modified
    do_op(0, 2, 2, 0, 9);      // R9 evict of line not held
    do_op(1, 0, 2, 0, 9);      // R9 memory holds written-back data
    do_op(1, 1, 14, 'h77, 4);  // R4
    do_op(0, 0, 14, 0, 7);     // R7
    do_op(1, 1, 14, 'h78, 5);  // R5 peer upgrades after downgrade, R6 on cache 0
    do_op(0, 0, 14, 0, 6);     // R6 invalidated copy misses
    repeat (4) @(posedge clk);
    @(negedge clk);
    ck(evq.size() == 0, "R2 all events seen", evq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected<20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule